// File: doc/BRIEF.md
# Segment LCD Frame Timing Generator

This block produces the digital timing for a multiplexed segment LCD. A two-stage clock chain (a power-of-two prescaler followed by a divide-by-16-to-31 stage) sets the length of one drive phase. A sequencer steps the common-line index through as many phases as the selected duty calls for. It then inserts a programmable number of idle dead-time phases before the next frame begins. At the start of every common phase, a pulse-on strobe is held for a programmable number of prescaled clock periods.

Segment data lives in eight 32-bit words, one per common line. Software writes these words into a shadow buffer and raises an update request. The shadow contents reach the live segment outputs only at the next start of frame, and at that moment an update-done flag is raised. A blink divider clocked by the phase clock can blank a selected group of segments during the off half of each blink period. Start-of-frame and update-done flags each have a write-one-to-clear input and an interrupt enable. The interrupt line is the OR of the enabled flags.

Top module: `lcdt_frame_gen`

## Requirements
- R1: One phase lasts 2^psc_cfg × (16 + div_cfg) clock cycles, with psc_cfg from 0 to 15 and div_cfg from 0 to 15. A frame is (commons + dead phases) phases long. The first phase starts on the edge at which enable is first seen high.
- R2: duty_cfg sets the number of commons: 0→1, 1→2, 2→3, 3→4, 4→8, 5→6. Codes 6 and 7 behave as 1. com_idx counts 0, 1, … commons−1 during the common phases of each frame.
- R3: After the commons come dead_cfg (0..7) dead phases. During a dead phase, dead_phase is 1 and com_idx, seg_out and pulse_on are all 0.
- R4: pulse_on is 1 during the first pulse_cfg × 2^psc_cfg cycles of every common phase and 0 otherwise. A pulse_cfg of 0 gives no pulse.
- R5: The blink state is off when bit (blink_div_cfg + 2) of the count of phases since enable is 1. While the blink state is off, the mask is cleared from seg_out. The mask depends on blink_mode_cfg: 0 none; 1 bit 0 while com_idx is 0; 2 bit 0 on every common; 3 all bits.
- R6: seg_out shows the active word of the current common. A write (wr_en, wr_idx, wr_data) goes only to the shadow word. Shadow words are copied to the active words only at a start of frame while an update is pending. Without a request, a write never reaches seg_out.
- R7: upd_req sets upd_pend. At the commit, upd_pend clears and upd_done sets. upd_clr clears upd_done, except that a commit in the same cycle wins.
- R8: sof_flag sets at every start of frame, including the first one after enable. sof_clr clears it. A start of frame in the same cycle as sof_clr leaves sof_flag set.
- R9: irq is 1 exactly when (sof_flag and sof_ie) or (upd_done and upd_ie).
- R10: All timing and display configuration inputs are sampled only at a start of frame. A change in the middle of a frame has no effect until the next frame.
- R11: on_flag follows enable one cycle later. While on_flag is 0, com_idx, dead_phase, seg_out and pulse_on are 0. Re-enabling restarts at phase 0. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the controller |
| psc_cfg | input | 4 | Prescaler exponent |
| div_cfg | input | 4 | Divider offset above 16 |
| duty_cfg | input | 3 | Duty code |
| dead_cfg | input | 3 | Dead phases per frame |
| pulse_cfg | input | 3 | Pulse-on length in prescaled periods |
| blink_div_cfg | input | 3 | Blink divider code |
| blink_mode_cfg | input | 2 | Blink target select |
| wr_en | input | 1 | Shadow word write strobe |
| wr_idx | input | 3 | Shadow word index |
| wr_data | input | 32 | Shadow word value |
| upd_req | input | 1 | Request a commit at next frame |
| sof_ie | input | 1 | Start-of-frame interrupt enable |
| upd_ie | input | 1 | Update-done interrupt enable |
| sof_clr | input | 1 | Clear start-of-frame flag |
| upd_clr | input | 1 | Clear update-done flag |
| on_flag | output | 1 | Controller running |
| com_idx | output | 3 | Active common index |
| dead_phase | output | 1 | Dead-time phase in progress |
| seg_out | output | 32 | Segment enables |
| pulse_on | output | 1 | Pulse-on strobe |
| sof_flag | output | 1 | Start-of-frame flag |
| upd_pend | output | 1 | Update pending |
| upd_done | output | 1 | Update-done flag |
| irq | output | 1 | Interrupt request |

## Verification
The start-of-frame event and a software clear of sof_flag can land on the same clock edge. The bench runs the shortest frame (16 cycles) from a known enable edge. It clears the flag once so that a later set is visible, then places sof_clr exactly on the edge of the next frame boundary. The flag must read 1 after that edge and must read 0 one cycle after a clear made away from a boundary. This separates set-over-clear priority from plain clear behaviour.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int PSC_W     = 4;
    localparam int DIV_W     = 4;
    localparam int FLD_W     = 3;
    localparam int PH_W      = 4;
    localparam int BLK_CNT_W = FLD_W + (1 << FLD_W) - 1;

    typedef enum logic [2:0] {
        DUTY_STATIC  = 3'd0,
        DUTY_HALF    = 3'd1,
        DUTY_THIRD   = 3'd2,
        DUTY_QUARTER = 3'd3,
        DUTY_EIGHTH  = 3'd4,
        DUTY_SIXTH   = 3'd5,
        DUTY_RSV6    = 3'd6,
        DUTY_RSV7    = 3'd7
    } duty_e;

    typedef enum logic [1:0] {
        BLK_NONE    = 2'd0,
        BLK_S0_C0   = 2'd1,
        BLK_S0_ALLC = 2'd2,
        BLK_ALL     = 2'd3
    } blink_e;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [DIV_W-1:0] div;
        duty_e            duty;
        logic [FLD_W-1:0] dead;
        logic [FLD_W-1:0] pulse;
        logic [FLD_W-1:0] bdiv;
        blink_e           bmode;
    } cfg_t;

    // Number of common lines driven for a duty code; reserved codes act as static.
    function automatic logic [PH_W-1:0] com_count(duty_e d);
        case (d)
            DUTY_HALF:    return PH_W'(2);
            DUTY_THIRD:   return PH_W'(3);
            DUTY_QUARTER: return PH_W'(4);
            DUTY_EIGHTH:  return PH_W'(8);
            DUTY_SIXTH:   return PH_W'(6);
            default:      return PH_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/lcdt_clkchain.sv
module lcdt_clkchain
    import lcdt_pkg::*;
#(
    parameter int PSC_BITS = PSC_W,
    parameter int DIV_BITS = DIV_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                restart,
    input  logic [PSC_BITS-1:0] psc,
    input  logic [DIV_BITS-1:0] div,
    output logic                ph_tick,
    output logic [DIV_BITS:0]   div_cnt
);
    localparam int PRE_BITS = (1 << PSC_BITS) - 1;
    localparam int DIV_BASE = 1 << DIV_BITS;

    logic [PRE_BITS-1:0] pre_cnt;
    logic [PRE_BITS-1:0] pre_mask;
    logic [DIV_BITS:0]   div_top;
    logic                pre_tick;

    assign pre_mask = {PRE_BITS{1'b1}} >> (PRE_BITS - int'(psc));
    assign div_top  = (DIV_BITS+1)'(DIV_BASE - 1) + {1'b0, div};
    assign pre_tick = run && ((pre_cnt & pre_mask) == pre_mask);
    assign ph_tick  = pre_tick && (div_cnt == div_top);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
            if (pre_tick) begin
                div_cnt <= ph_tick ? '0 : div_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcdt_sequencer.sv
module lcdt_sequencer
    import lcdt_pkg::*;
#(
    parameter int BLK_BITS = BLK_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             ph_tick,
    input  logic [PH_W-1:0]  n_com,
    input  logic [FLD_W-1:0] n_dead,
    input  logic [FLD_W-1:0] bdiv,
    output logic [PH_W-1:0]  phase,
    output logic             frame_end,
    output logic             blink_off
);
    logic [BLK_BITS-1:0] blk_cnt;
    logic [PH_W-1:0]     n_total;

    assign n_total   = n_com + PH_W'(n_dead);
    assign frame_end = ph_tick && (phase == n_total - 1'b1);
    assign blink_off = blk_cnt[int'(bdiv) + 2];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase   <= '0;
            blk_cnt <= '0;
        end else if (ph_tick) begin
            phase   <= frame_end ? '0 : phase + 1'b1;
            blk_cnt <= blk_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lcdt_databuf.sv
module lcdt_databuf #(
    parameter int SEG_W = 32,
    parameter int N_COM = 8,
    localparam int IDX_W = $clog2(N_COM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEG_W-1:0] wr_data,
    input  logic             commit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SEG_W-1:0] rd_data
);
    logic [SEG_W-1:0] shadow [N_COM];
    logic [SEG_W-1:0] active [N_COM];

    for (genvar g = 0; g < N_COM; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[g] <= '0;
                active[g] <= '0;
            end else begin
                if (wr_en && (wr_idx == IDX_W'(g))) shadow[g] <= wr_data;
                if (commit) active[g] <= shadow[g];
            end
        end
    end

    assign rd_data = active[rd_idx];

endmodule

// File: rtl/lcdt_frame_gen.sv
module lcdt_frame_gen
    import lcdt_pkg::*;
#(
    parameter int SEG_W = 32,
    parameter int N_COM = 8,
    localparam int IDX_W = $clog2(N_COM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [PSC_W-1:0] psc_cfg,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic [2:0]       duty_cfg,
    input  logic [FLD_W-1:0] dead_cfg,
    input  logic [FLD_W-1:0] pulse_cfg,
    input  logic [FLD_W-1:0] blink_div_cfg,
    input  logic [1:0]       blink_mode_cfg,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEG_W-1:0] wr_data,
    input  logic             upd_req,
    input  logic             sof_ie,
    input  logic             upd_ie,
    input  logic             sof_clr,
    input  logic             upd_clr,
    output logic             on_flag,
    output logic [IDX_W-1:0] com_idx,
    output logic             dead_phase,
    output logic [SEG_W-1:0] seg_out,
    output logic             pulse_on,
    output logic             sof_flag,
    output logic             upd_pend,
    output logic             upd_done,
    output logic             irq
);
    logic             on_q;
    cfg_t             cfg_in;
    cfg_t             cfg_act;
    logic             start;
    logic             run;
    logic             fr_evt;
    logic             commit;
    logic             ph_tick;
    logic             frame_end;
    logic             blink_off;
    logic [DIV_W:0]   div_cnt;
    logic [PH_W-1:0]  phase;
    logic [PH_W-1:0]  n_com;
    logic             in_com;
    logic [SEG_W-1:0] word;
    logic [SEG_W-1:0] bmask;

    assign cfg_in = '{psc:   psc_cfg,
                      div:   div_cfg,
                      duty:  duty_e'(duty_cfg),
                      dead:  dead_cfg,
                      pulse: pulse_cfg,
                      bdiv:  blink_div_cfg,
                      bmode: blink_e'(blink_mode_cfg)};

    assign start  = enable && !on_q;
    assign run    = enable && on_q;
    assign fr_evt = start || frame_end;
    assign commit = fr_evt && upd_pend;
    assign n_com  = com_count(cfg_act.duty);

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q    <= 1'b0;
            cfg_act <= '0;
        end else begin
            on_q <= enable;
            if (fr_evt) cfg_act <= cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_pend <= 1'b0;
            upd_done <= 1'b0;
            sof_flag <= 1'b0;
        end else begin
            if (commit)       upd_pend <= 1'b0;
            else if (upd_req) upd_pend <= 1'b1;
            if (commit)       upd_done <= 1'b1;
            else if (upd_clr) upd_done <= 1'b0;
            if (fr_evt)       sof_flag <= 1'b1;
            else if (sof_clr) sof_flag <= 1'b0;
        end
    end

    lcdt_clkchain u_clk (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (fr_evt),
        .psc     (cfg_act.psc),
        .div     (cfg_act.div),
        .ph_tick (ph_tick),
        .div_cnt (div_cnt)
    );

    lcdt_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .clear     (!enable || start),
        .ph_tick   (ph_tick),
        .n_com     (n_com),
        .n_dead    (cfg_act.dead),
        .bdiv      (cfg_act.bdiv),
        .phase     (phase),
        .frame_end (frame_end),
        .blink_off (blink_off)
    );

    lcdt_databuf #(.SEG_W(SEG_W), .N_COM(N_COM)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .commit  (commit),
        .rd_idx  (com_idx),
        .rd_data (word)
    );

    assign in_com     = on_q && (phase < n_com);
    assign dead_phase = on_q && !in_com;
    assign com_idx    = in_com ? phase[IDX_W-1:0] : '0;

    always_comb begin
        case (cfg_act.bmode)
            BLK_S0_C0:   bmask = (com_idx == '0) ? SEG_W'(1) : '0;
            BLK_S0_ALLC: bmask = SEG_W'(1);
            BLK_ALL:     bmask = '1;
            default:     bmask = '0;
        endcase
    end

    assign seg_out  = in_com ? (word & ~(blink_off ? bmask : '0)) : '0;
    assign pulse_on = in_com && (div_cnt < (DIV_W+1)'(cfg_act.pulse));
    assign irq      = (sof_flag && sof_ie) || (upd_done && upd_ie);
    assign on_flag  = on_q;

endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker #(
    parameter int SEG_W = 32,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             on_flag,
    input logic [IDX_W-1:0] com_idx,
    input logic             dead_phase,
    input logic [SEG_W-1:0] seg_out,
    input logic             pulse_on,
    input logic             sof_flag,
    input logic             sof_clr,
    input logic             upd_pend,
    input logic             upd_done,
    input logic             upd_clr
);
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !on_flag |-> (seg_out == '0 && !pulse_on && !dead_phase && com_idx == '0)); // R11

    AST_DEAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        dead_phase |-> (seg_out == '0 && !pulse_on && com_idx == '0)); // R3

    AST_SOF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sof_flag && !sof_clr) |=> sof_flag); // R8

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (upd_done && !upd_clr) |=> upd_done); // R7

    AST_COMMIT_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_pend) |-> upd_done); // R6

    AST_COM_STEP: assert property (@(posedge clk) disable iff (rst)
        (on_flag && $past(on_flag) && !dead_phase && !$past(dead_phase)
         && com_idx != $past(com_idx))
        |-> (com_idx == '0 || com_idx == $past(com_idx) + 1'b1)); // R2

endmodule

bind lcdt_frame_gen lcdt_checker #(.SEG_W(SEG_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .on_flag    (on_flag),
    .com_idx    (com_idx),
    .dead_phase (dead_phase),
    .seg_out    (seg_out),
    .pulse_on   (pulse_on),
    .sof_flag   (sof_flag),
    .sof_clr    (sof_clr),
    .upd_pend   (upd_pend),
    .upd_done   (upd_done),
    .upd_clr    (upd_clr)
);

// File: tb/lcdt_frame_gen_tb.sv
module lcdt_frame_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [3:0]  psc_cfg;
    logic [3:0]  div_cfg;
    logic [2:0]  duty_cfg;
    logic [2:0]  dead_cfg;
    logic [2:0]  pulse_cfg;
    logic [2:0]  blink_div_cfg;
    logic [1:0]  blink_mode_cfg;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [31:0] wr_data;
    logic        upd_req;
    logic        sof_ie;
    logic        upd_ie;
    logic        sof_clr;
    logic        upd_clr;
    logic        on_flag;
    logic [2:0]  com_idx;
    logic        dead_phase;
    logic [31:0] seg_out;
    logic        pulse_on;
    logic        sof_flag;
    logic        upd_pend;
    logic        upd_done;
    logic        irq;

    int          checks   = 0;
    int          failures = 0;
    int          cyc      = 0;
    logic [31:0] words [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdt_frame_gen u_dut (
        .clk(clk), .rst(rst), .enable(enable),
        .psc_cfg(psc_cfg), .div_cfg(div_cfg), .duty_cfg(duty_cfg),
        .dead_cfg(dead_cfg), .pulse_cfg(pulse_cfg),
        .blink_div_cfg(blink_div_cfg), .blink_mode_cfg(blink_mode_cfg),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .upd_req(upd_req),
        .sof_ie(sof_ie), .upd_ie(upd_ie), .sof_clr(sof_clr), .upd_clr(upd_clr),
        .on_flag(on_flag), .com_idx(com_idx), .dead_phase(dead_phase),
        .seg_out(seg_out), .pulse_on(pulse_on), .sof_flag(sof_flag),
        .upd_pend(upd_pend), .upd_done(upd_done), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not end, actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int ncom_of(input int d);
        case (d)
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 8;
            5: return 6;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] bmask_of(input int mode, input int com);
        case (mode)
            1: return (com == 0) ? 32'h1 : 32'h0;
            2: return 32'h1;
            3: return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    // Enable with a configuration and compare every cycle with the arithmetic model.
    task automatic run_cfg(input int psc, input int div, input int duty, input int dead,
                           input int pulse, input int bdiv, input int bmode,
                           input int ncyc, input string req);
        int p  = 1 << psc;
        int d  = 16 + div;
        int nc = ncom_of(duty);
        int tot = nc + dead;
        @(negedge clk);
        psc_cfg = 4'(psc); div_cfg = 4'(div); duty_cfg = 3'(duty);
        dead_cfg = 3'(dead); pulse_cfg = 3'(pulse);
        blink_div_cfg = 3'(bdiv); blink_mode_cfg = 2'(bmode);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        for (int t = 0; t < ncyc; t++) begin
            int ph_all = (t / p) / d;
            int ph     = ph_all % tot;
            int dc     = (t / p) % d;
            bit e_dead = (ph >= nc);
            int e_com  = e_dead ? 0 : ph;
            bit e_pls  = !e_dead && (dc < pulse);
            bit boff   = ((ph_all >> (bdiv + 2)) & 1) == 1;
            logic [31:0] e_seg;
            e_seg = e_dead ? 32'h0 : (words[e_com] & ~(boff ? bmask_of(bmode, e_com) : 32'h0));
            check(com_idx == 3'(e_com) && dead_phase == e_dead && pulse_on == e_pls, req,
                  "com/dead/pulse", {com_idx, dead_phase, pulse_on},
                  {3'(e_com), e_dead, e_pls});
            check(seg_out == e_seg, req, "seg_out", seg_out, e_seg);
            @(negedge clk);
        end
        enable = 1'b0;
    endtask

    initial begin
        rst = 1'b1; enable = 1'b0;
        psc_cfg = '0; div_cfg = '0; duty_cfg = '0; dead_cfg = '0; pulse_cfg = '0;
        blink_div_cfg = '0; blink_mode_cfg = '0;
        wr_en = 1'b0; wr_idx = '0; wr_data = '0; upd_req = 1'b0;
        sof_ie = 1'b0; upd_ie = 1'b0; sof_clr = 1'b0; upd_clr = 1'b0;
        for (int i = 0; i < 8; i++) words[i] = (32'h9E37_79B9 * 32'(i + 1)) | 32'h1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check(on_flag == 0 && seg_out == 0 && com_idx == 0 && pulse_on == 0 && dead_phase == 0,
              "R11", "reset outputs", {on_flag, com_idx, pulse_on}, 0);
        check(sof_flag == 0 && upd_pend == 0 && upd_done == 0 && irq == 0,
              "R8 R7", "reset flags", {sof_flag, upd_pend, upd_done, irq}, 0);

        // Load shadow words and request an update while stopped
        for (int i = 0; i < 8; i++) begin
            wr_en = 1'b1; wr_idx = 3'(i); wr_data = words[i];
            @(negedge clk);
        end
        wr_en = 1'b0;
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        check(upd_pend == 1 && upd_done == 0, "R7", "pending after request",
              {upd_pend, upd_done}, 2'b10);

        // Sweep of clock chain, duty codes (incl. reserved), dead time and pulse window
        for (int psc = 0; psc < 2; psc++)
            for (int dv = 0; dv < 4; dv += 3)
                for (int duty = 0; duty < 8; duty++)
                    for (int dead = 0; dead < 3; dead += 2) begin
                        int tot = ncom_of(duty) + dead;
                        run_cfg(psc, dv, duty, dead, (dv == 0) ? 0 : 5, 0, 0,
                                2 * tot * (1 << psc) * (16 + dv) + 3, "R1 R2 R3 R4");
                        if (psc == 0 && dv == 0 && duty == 0 && dead == 0)
                            check(upd_pend == 0 && upd_done == 1, "R6 R7",
                                  "commit at first frame", {upd_pend, upd_done}, 2'b01);
                    end

        // Long prescale and divide
        run_cfg(2, 15, 3, 0, 7, 0, 0, 600, "R1 R4");

        // Blink modes and divider
        for (int bm = 0; bm < 4; bm++)
            for (int bd = 0; bd < 2; bd++)
                run_cfg(0, 0, 2, 1, 2, bd, bm, ((8 << bd) * 16) * 2 + 10, "R5");

        // Start-of-frame flag, set/clear collision and interrupt
        @(negedge clk);
        psc_cfg = 0; div_cfg = 0; duty_cfg = 0; dead_cfg = 0; pulse_cfg = 0;
        blink_mode_cfg = 0; blink_div_cfg = 0;
        enable = 1'b0; sof_clr = 1'b1; upd_clr = 1'b1;
        @(negedge clk);
        sof_clr = 1'b0; upd_clr = 1'b0;
        check(sof_flag == 0 && upd_done == 0 && irq == 0, "R8 R7", "cleared flags",
              {sof_flag, upd_done, irq}, 0);
        sof_ie = 1'b1;
        enable = 1'b1;
        @(negedge clk);                       // t=0
        check(on_flag == 1, "R11", "on_flag after enable", on_flag, 1);
        check(sof_flag == 1 && irq == 1, "R8 R9", "sof at enable", {sof_flag, irq}, 2'b11);
        sof_clr = 1'b1;
        @(negedge clk);                       // t=1
        sof_clr = 1'b0;
        check(sof_flag == 0 && irq == 0, "R8 R9", "sof cleared", {sof_flag, irq}, 0);
        repeat (14) @(negedge clk);           // t=15
        check(sof_flag == 0, "R8", "sof before boundary", sof_flag, 0);
        @(negedge clk);                       // t=16
        check(sof_flag == 1, "R8", "sof at boundary", sof_flag, 1);
        sof_clr = 1'b1;
        @(negedge clk);                       // t=17
        sof_clr = 1'b0;
        check(sof_flag == 0, "R8", "sof cleared mid-frame", sof_flag, 0);
        repeat (14) @(negedge clk);           // t=31
        sof_clr = 1'b1;
        @(negedge clk);                       // t=32, boundary with clear
        sof_clr = 1'b0;
        check(sof_flag == 1, "R8", "set wins over clear", sof_flag, 1);
        sof_ie = 1'b0;
        #1;
        check(irq == 0, "R9", "irq masked", irq, 0);
        upd_ie = 1'b1;
        #1;
        check(irq == 0, "R9", "irq with done low", irq, 0);
        upd_ie = 1'b0;

        // Disable and restart
        enable = 1'b0;
        @(negedge clk);
        check(on_flag == 0 && seg_out == 0 && pulse_on == 0, "R11", "outputs when off",
              {on_flag, pulse_on}, 0);
        enable = 1'b1;
        @(negedge clk);
        check(on_flag == 1 && com_idx == 0 && seg_out == words[0], "R11", "restart phase 0",
              seg_out, words[0]);

        // Shadow write, request and commit
        @(negedge clk);
        duty_cfg = 2;
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);                       // t=0
        check(seg_out == words[0] && com_idx == 0, "R6", "active word at start", seg_out, words[0]);
        repeat (5) @(negedge clk);            // t=5
        wr_en = 1'b1; wr_idx = 0; wr_data = 32'hC0DE_0F0F;
        @(negedge clk);                       // t=6
        wr_en = 1'b0;
        repeat (42) @(negedge clk);           // t=48
        check(seg_out == words[0], "R6", "write without request ignored", seg_out, words[0]);
        check(upd_done == 0 && upd_pend == 0, "R7", "no commit without request",
              {upd_pend, upd_done}, 0);
        upd_req = 1'b1;
        @(negedge clk);                       // t=49
        upd_req = 1'b0;
        check(upd_pend == 1 && upd_done == 0, "R7", "pending", {upd_pend, upd_done}, 2'b10);
        repeat (46) @(negedge clk);           // t=95
        check(seg_out == words[2] && upd_pend == 1, "R6", "old data until frame", seg_out, words[2]);
        @(negedge clk);                       // t=96
        check(seg_out == 32'hC0DE_0F0F, "R6", "new data at frame", seg_out, 32'hC0DE_0F0F);
        check(upd_pend == 0 && upd_done == 1, "R7", "commit flags", {upd_pend, upd_done}, 2'b01);
        upd_ie = 1'b1;
        #1;
        check(irq == 1, "R9", "irq on done", irq, 1);
        upd_ie = 1'b0;
        words[0] = 32'hC0DE_0F0F;
        upd_clr = 1'b1;
        @(negedge clk);                       // t=97
        upd_clr = 1'b0;
        check(upd_done == 0, "R7", "done cleared", upd_done, 0);

        // Configuration change mid-frame takes effect at next frame
        duty_cfg = 1;
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);                       // t=0
        repeat (5) @(negedge clk);            // t=5
        div_cfg = 15;
        repeat (15) @(negedge clk);           // t=20
        check(com_idx == 1, "R10", "old divider kept in frame", com_idx, 1);
        repeat (30) @(negedge clk);           // t=50
        check(com_idx == 0, "R10", "new divider phase 0", com_idx, 0);
        repeat (12) @(negedge clk);           // t=62
        check(com_idx == 0, "R10 R1", "phase 0 end", com_idx, 0);
        @(negedge clk);                       // t=63
        check(com_idx == 1 && seg_out == words[1], "R10 R1", "phase 1 start", com_idx, 1);
        enable = 1'b0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule